// File: doc/BRIEF.md
# Carry-Lookahead Binary Adder

This block adds two WIDTH-bit operands and a carry input in pure combinational logic. Each bit position forms two local terms from its operand bits: a generate term (both bits set) and a generate-or-propagate term (either bit set). The carry out of every position comes straight from these terms and the carry input as a flat sum of products. No carry passes from one bit cell to the next, so the carry logic is two levels deep at any width.

Each sum bit is the XOR of its two operand bits and the carry entering that position. The same logic serves unsigned and two's-complement operands; only the reading of the result changes. For unsigned use, the carry out of the top position extends the sum by one bit. For signed use, the block also gives a result one bit wider that cannot overflow. Its top bit is formed from the top operand bits and the carry leaving the top position. The per-position carries are brought out so that wider datapaths can tap them.

Top module: `cla_adder`

## Requirements
- R1: For every position n, carry_o[n] is 1 whenever p_i[n] and q_i[n] are both 1, whatever the lower bits and cin_i.
- R2: For every position n, carry_o[n] is 0 whenever p_i[n] and q_i[n] are both 0, whatever the lower bits and cin_i.
- R3: When exactly one of p_i[n] and q_i[n] is 1, carry_o[n] equals the carry entering position n. That carry is cin_i for n = 0 and carry_o[n-1] otherwise.
- R4: sum_o[n] equals p_i[n] XOR q_i[n] XOR the carry entering position n, as defined in R3.
- R5: Read as an unsigned number of WIDTH+1 bits, {carry_o[WIDTH-1], sum_o} equals p_i + q_i + cin_i.
- R6: ext_sum_o, read as a two's-complement number of WIDTH+1 bits, equals the signed value of p_i plus the signed value of q_i plus cin_i.
- R7: ext_sum_o[WIDTH] equals p_i[WIDTH-1] XOR q_i[WIDTH-1] XOR carry_o[WIDTH-1], and ext_sum_o[WIDTH-1:0] equals sum_o.
- R8: When p_i XOR q_i is all ones, cin_i passes to carry_o[WIDTH-1] unchanged. When p_i XOR q_i has at least one zero bit, carry_o[WIDTH-1] does not depend on cin_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| p_i | input | WIDTH | First operand |
| q_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into position 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | WIDTH | Carry out of each position; the top bit is the unsigned extension bit |
| ext_sum_o | output | WIDTH+1 | Sign-extended sum that cannot overflow |

## Verification
The assertions are immediate checks that are evaluated whenever the combinational inputs settle. They assume only that p_i, q_i and cin_i carry known 0/1 values and that WIDTH is at least 2. The stimulus sweeps every operand pair with both carry-input values. It changes inputs only on the falling clock edge and reads outputs a settling delay later, so every sampled value is a fully settled known state. The R8 sweep holds the operands fixed and toggles only cin_i, so any effect of cin_i on the top carry is seen at the ports.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned CLA_DEFAULT_WIDTH = 4;

  // Single-step carry recurrence, used only as an independent cross-check.
  function automatic logic carry_step(input logic gen, input logic gen_or_prop, input logic c_in);
    return gen | (gen_or_prop & c_in);
  endfunction

  // Full-adder sum, used as an independent cross-check.
  function automatic logic sum_bit(input logic a, input logic b, input logic c_in);
    return a ^ b ^ c_in;
  endfunction

endpackage

// File: rtl/cla_bit_terms.sv
module cla_bit_terms #(
  parameter int unsigned WIDTH = cla_pkg::CLA_DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] gop_o,
  output logic [WIDTH-1:0] half_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign gen_o[b]  = p_i[b] & q_i[b];
    assign gop_o[b]  = p_i[b] | q_i[b];
    assign half_o[b] = p_i[b] ^ q_i[b];
  end

  always_comb begin
    for (int b = 0; b < WIDTH; b++) begin
      // generate implies generate-or-propagate (R1)
      p_gen_in_gop_r1: assert (!gen_o[b] || gop_o[b])
        else $error("gen without gop at bit %0d", b);
      // a set half-sum excludes generate (R3)
      p_half_excl_gen_r3: assert (!(half_o[b] && gen_o[b]))
        else $error("half and gen both set at bit %0d", b);
    end
  end

endmodule

// File: rtl/cla_carry_net.sv
module cla_carry_net #(
  parameter int unsigned WIDTH = cla_pkg::CLA_DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] gop_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] carry_o
);

  // Flat sum of products per position: n+2 terms for position n.
  for (genvar n = 0; n < WIDTH; n++) begin : g_pos
    logic [n+1:0] terms;

    always_comb begin
      terms[0] = gen_i[n];
      for (int k = 0; k < n; k++) begin
        terms[k+1] = gen_i[k];
        for (int j = k + 1; j <= n; j++) begin
          terms[k+1] = terms[k+1] & gop_i[j];
        end
      end
      terms[n+1] = cin_i;
      for (int j = 0; j <= n; j++) begin
        terms[n+1] = terms[n+1] & gop_i[j];
      end
    end

    assign carry_o[n] = |terms;
  end

  always_comb begin
    // flat expansion must agree with the one-step recurrence (R3)
    p_lsb_step_r3: assert (carry_o[0] == cla_pkg::carry_step(gen_i[0], gop_i[0], cin_i))
      else $error("carry 0 mismatch");
    for (int n = 1; n < WIDTH; n++) begin
      p_step_r3: assert (carry_o[n] == cla_pkg::carry_step(gen_i[n], gop_i[n], carry_o[n-1]))
        else $error("carry %0d mismatch", n);
      // no operand bit set kills the carry (R2)
      p_kill_r2: assert (gop_i[n] || !carry_o[n])
        else $error("carry %0d set with both bits clear", n);
    end
  end

endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage #(
  parameter int unsigned WIDTH = cla_pkg::CLA_DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] half_i,
  input  logic [WIDTH-1:0] carry_i,
  input  logic             cin_i,
  input  logic             p_top_i,
  input  logic             q_top_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH:0]   ext_sum_o
);

  logic [WIDTH-1:0] c_enter;

  assign c_enter = {carry_i[WIDTH-2:0], cin_i};
  assign sum_o   = half_i ^ c_enter;

  // Sign bit of the widened result uses the carry leaving the top position.
  assign ext_sum_o = {p_top_i ^ q_top_i ^ carry_i[WIDTH-1], sum_o};

  always_comb begin
    for (int n = 0; n < WIDTH; n++) begin
      p_sum_bit_r4: assert (sum_o[n] == (half_i[n] ^ ((n == 0) ? cin_i : carry_i[n-1])))
        else $error("sum bit %0d mismatch", n);
    end
    p_ext_low_r7: assert (ext_sum_o[WIDTH-1:0] == sum_o)
      else $error("extended low bits differ from sum");
  end

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned WIDTH = cla_pkg::CLA_DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] carry_o,
  output logic [WIDTH:0]   ext_sum_o
);

  localparam int unsigned XW = WIDTH + 1;

  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] gop;
  logic [WIDTH-1:0] half;

  cla_bit_terms #(.WIDTH(WIDTH)) u_terms (
    .p_i   (p_i),
    .q_i   (q_i),
    .gen_o (gen),
    .gop_o (gop),
    .half_o(half)
  );

  cla_carry_net #(.WIDTH(WIDTH)) u_carry (
    .gen_i  (gen),
    .gop_i  (gop),
    .cin_i  (cin_i),
    .carry_o(carry_o)
  );

  cla_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .half_i   (half),
    .carry_i  (carry_o),
    .cin_i    (cin_i),
    .p_top_i  (p_i[WIDTH-1]),
    .q_top_i  (q_i[WIDTH-1]),
    .sum_o    (sum_o),
    .ext_sum_o(ext_sum_o)
  );

  logic [XW-1:0] ref_uns;
  logic [XW-1:0] ref_sgn;

  assign ref_uns = {1'b0, p_i} + {1'b0, q_i} + {{WIDTH{1'b0}}, cin_i};
  assign ref_sgn = {p_i[WIDTH-1], p_i} + {q_i[WIDTH-1], q_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    p_uns_total_r5: assert ({carry_o[WIDTH-1], sum_o} == ref_uns)
      else $error("unsigned total mismatch");
    p_no_overflow_r6: assert (ext_sum_o == ref_sgn)
      else $error("signed widened total mismatch");
    p_sign_bit_r7: assert (ext_sum_o[WIDTH] == (p_i[WIDTH-1] ^ q_i[WIDTH-1] ^ carry_o[WIDTH-1]))
      else $error("sign bit mismatch");
    p_pass_through_r8: assert (!(&(p_i ^ q_i)) || (carry_o[WIDTH-1] == cin_i))
      else $error("all-propagate carry mismatch");
    for (int n = 0; n < WIDTH; n++) begin
      p_generate_r1: assert (!(p_i[n] && q_i[n]) || carry_o[n])
        else $error("generate missed at bit %0d", n);
    end
  end

endmodule

// File: tb/cla_adder_bench.sv
module cla_adder_bench;

  localparam int W    = 4;
  localparam int SPAN = 1 << W;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] p;
  logic [W-1:0] q;
  logic         cin;
  logic [W-1:0] sum;
  logic [W-1:0] carry;
  logic [W:0]   ext_sum;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  cla_adder #(.WIDTH(W)) u_cla_adder (
    .p_i      (p),
    .q_i      (q),
    .cin_i    (cin),
    .sum_o    (sum),
    .carry_o  (carry),
    .ext_sum_o(ext_sum)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s p=%0d q=%0d cin=%0d actual=%0d expected=%0d", req, p, q, cin, got, exp);
    end
  endtask

  task automatic apply(input int pv, input int qv, input int cv);
    @(negedge clk);
    p   = W'(pv);
    q   = W'(qv);
    cin = cv[0];
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    p     = '0;
    q     = '0;
    cin   = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Quiet state: zero operands give zero everywhere (R5, R6)
    apply(0, 0, 0);
    check("R5 zero sum", int'(sum), 0);
    check("R5 zero carry", int'(carry), 0);
    check("R6 zero ext", int'(ext_sum), 0);

    // Exhaustive sweep
    for (int cv = 0; cv < 2; cv++) begin
      for (int pv = 0; pv < SPAN; pv++) begin
        for (int qv = 0; qv < SPAN; qv++) begin
          int ps;
          int qs;
          int exp_s;
          int got_s;
          int c_in;
          apply(pv, qv, cv);
          // R5: unsigned total from top carry and sum
          check("R5 unsigned", int'({carry[W-1], sum}), pv + qv + cv);
          // R6: signed widened total
          ps    = (pv >= SPAN / 2) ? pv - SPAN : pv;
          qs    = (qv >= SPAN / 2) ? qv - SPAN : qv;
          exp_s = ps + qs + cv;
          got_s = ext_sum[W] ? int'(ext_sum) - 2 * SPAN : int'(ext_sum);
          check("R6 signed", got_s, exp_s);
          // R7: sign bit and low bits
          check("R7 sign bit", int'(ext_sum[W]), int'(p[W-1] ^ q[W-1] ^ carry[W-1]));
          check("R7 low bits", int'(ext_sum[W-1:0]), int'(sum));
          // R1..R4 per position, expected from arithmetic on low slices
          c_in = cv;
          for (int n = 0; n < W; n++) begin
            int pb;
            int qb;
            int low_mask;
            int exp_c;
            pb       = (pv >> n) & 1;
            qb       = (qv >> n) & 1;
            low_mask = (2 << n) - 1;
            exp_c    = (((pv & low_mask) + (qv & low_mask) + cv) >> (n + 1)) & 1;
            if (pb == 1 && qb == 1) check("R1 generate", int'(carry[n]), 1);
            else if (pb == 0 && qb == 0) check("R2 kill", int'(carry[n]), 0);
            else check("R3 propagate", int'(carry[n]), c_in);
            check("R4 sum bit", int'(sum[n]), pb ^ qb ^ c_in);
            c_in = exp_c;
          end
        end
      end
    end

    // R8: toggle cin_i with operands held
    for (int pv = 0; pv < SPAN; pv++) begin
      for (int qv = 0; qv < SPAN; qv++) begin
        int top0;
        int top1;
        apply(pv, qv, 0);
        top0 = int'(carry[W-1]);
        apply(pv, qv, 1);
        top1 = int'(carry[W-1]);
        if ((pv ^ qv) == SPAN - 1) begin
          check("R8 pass cin0", top0, 0);
          check("R8 pass cin1", top1, 1);
        end else begin
          check("R8 independent", top1, top0);
        end
      end
    end

    // Boundary pairs named explicitly
    apply(SPAN - 1, SPAN - 1, 1);
    check("R5 max unsigned", int'({carry[W-1], sum}), 2 * SPAN - 1);
    check("R6 max both -1", int'(ext_sum), 2 * SPAN - 1);
    apply(SPAN / 2, SPAN / 2, 0);
    check("R6 most negative", int'(ext_sum), SPAN);
    apply(SPAN / 2 - 1, SPAN / 2 - 1, 1);
    check("R6 most positive", int'(ext_sum), SPAN - 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule